// File: doc/BRIEF.md
# Instruction-Count Deadman Timer

This block is a safety timer for mission-critical software. It does not count clock cycles. It counts instruction-fetch strobes from the processor, so a program that stops making progress, or races down an unexpected path, is caught by how many instructions it has executed. Once enabled, the count climbs toward a programmable limit. Software keeps the timer alive with an ordered two-key handshake. First it writes an arming key to the pre-clear register. Then it writes a second key to the clear register. The second key is accepted only after the count has passed a programmable window threshold, which stops a runaway loop from servicing the timer too early.

A wrong first key and a wrong or badly timed second key are each recorded in their own sticky status flag. Reaching the limit raises a timeout flag and also sets a bit in a reset-cause register that a reset generator can sample. Any of the three flags drives the event output.

Software reaches every register through a 32-bit word port. Each register has three write addresses: plain, bit-clear and bit-set. This lets single bits change without a read-modify-write.

Top module: `fetch_deadman`

## Requirements
- R1: Address bits 7:4 select a register slot: control 0x0, pre-clear 0x1, clear 0x2, status 0x3, count 0x4, limit 0x6, interval 0x7, cause 0x8. Bits 3:2 pick the write alias: 0 plain write, 1 clear the bits written as 1, 2 set the bits written as 1, 3 plain write. Writes with bits 1:0 not zero are ignored. Reads return the register whatever the alias is. After reset, control, status, count and cause read 0, and limit and interval read their parameter values.
- R2: Control bit 15 enables the timer. While it is 0, the count is held at 0 and writes to pre-clear and clear have no effect.
- R3: While enabled, the count rises by one on each clock with `fetch_i` high and never goes past the limit.
- R4: The fetch that brings the count to the limit sets status bit 5 and cause bit 5. The count then holds.
- R5: Status bit 0 reads 1 exactly when the timer is enabled and count >= interval.
- R6: A pre-clear write whose bits 15:8 equal 0x40 arms the timer. Any other pre-clear value sets status bit 7 and disarms. A value written through the clear alias counts as zero.
- R7: A clear write with the full word 0x00000008, made while armed and with the window open, resets the count to 0 and disarms. Any other clear write sets status bit 6, disarms, and leaves the count unchanged.
- R8: `event_o` is high exactly when any of status bits 7:5 is set.
- R9: Status flags clear only through the status clear alias, one per data bit in 7:5. Plain and set writes to status change nothing.
- R10: Cause bit 5 (also on `cause_o`) stays set until it is written through the cause clear alias. Clearing the status timeout flag does not touch it.
- R11: Every write in the clock cycle right after the enable bit goes from 1 to 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_i | input | 1 | Instruction-fetch strobe, one count per cycle high |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Byte address: slot, alias and alignment bits |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the addressed slot |
| event_o | output | 1 | Timeout or bad-key event |
| cause_o | output | 1 | Deadman reset-cause bit |

## Verification
The bench sweeps the fetch count at which service is attempted across every window threshold below two small limits, and checks the result of each attempt. A window compare that is off by one would accept or reject service at exactly count == interval, and the sweep lands on that point for every threshold. Further tests cover a wrong first key, a wrong second value, a second key with no arming first key, and expiry past the limit. A counter that wraps or keeps counting shows up as a count above the limit. Flags that clear on plain writes, or a cause bit tied to the status flag, show up as changed read values. A missing blackout cycle shows up as a limit or enable write that lands when it should have been dropped.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
  localparam int DATA_W = 32;
  localparam int NSLOT  = 8;

  typedef enum logic [1:0] {
    AL_PLAIN = 2'd0,
    AL_CLR   = 2'd1,
    AL_SET   = 2'd2,
    AL_ALT   = 2'd3
  } alias_e;

  localparam int RG_CTL = 0;
  localparam int RG_PRE = 1;
  localparam int RG_CLR = 2;
  localparam int RG_STA = 3;
  localparam int RG_CNT = 4;
  localparam int RG_LIM = 5;
  localparam int RG_WIN = 6;
  localparam int RG_CAU = 7;

  localparam int EN_BIT    = 15;
  localparam int CAUSE_BIT = 5;

  localparam logic [7:0]        ARM_KEY  = 8'h40;
  localparam logic [DATA_W-1:0] SVC_KEY  = 32'h0000_0008;

  // address slot (bits 7:4) for each register index
  function automatic logic [3:0] slot_of(input int idx);
    case (idx)
      RG_CTL:  slot_of = 4'h0;
      RG_PRE:  slot_of = 4'h1;
      RG_CLR:  slot_of = 4'h2;
      RG_STA:  slot_of = 4'h3;
      RG_CNT:  slot_of = 4'h4;
      RG_LIM:  slot_of = 4'h6;
      RG_WIN:  slot_of = 4'h7;
      RG_CAU:  slot_of = 4'h8;
      default: slot_of = 4'hF;
    endcase
  endfunction

  function automatic logic apply_bit(input alias_e al, input logic cur, input logic wb);
    case (al)
      AL_CLR:  apply_bit = cur & ~wb;
      AL_SET:  apply_bit = cur | wb;
      default: apply_bit = wb;
    endcase
  endfunction
endpackage

// File: rtl/dmt_regdec.sv
module dmt_regdec
  import dmt_pkg::*;
#(
  parameter int NREG = NSLOT
) (
  input  logic            wr_i,
  input  logic [7:0]      addr_i,
  input  logic            blk_i,
  output logic [NREG-1:0] we_o,
  output alias_e          al_o
);
  logic ok;
  assign ok   = wr_i && !blk_i && (addr_i[1:0] == 2'b00);
  assign al_o = alias_e'(addr_i[3:2]);

  for (genvar g = 0; g < NREG; g++) begin : g_sel
    assign we_o[g] = ok && (addr_i[7:4] == slot_of(g));
  end
endmodule

// File: rtl/dmt_counter.sv
module dmt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             fetch_i,
  input  logic             svc_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic [CNT_W-1:0] win_i,
  input  logic             tmo_clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             win_open_o,
  output logic             tmo_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             tmo_q, tmo_d;
  logic             at_lim, step;

  assign cnt_inc  = cnt_q + CNT_W'(1);
  assign at_lim   = (cnt_q >= limit_i);
  assign step     = en_i && fetch_i && !at_lim && !svc_i;
  assign expire_o = step && (cnt_inc == limit_i);

  always_comb begin
    cnt_d = cnt_q;
    if (!en_i)      cnt_d = '0;
    else if (svc_i) cnt_d = '0;
    else if (step)  cnt_d = cnt_inc;
  end

  always_comb begin
    tmo_d = tmo_q;
    if (expire_o)       tmo_d = 1'b1;
    else if (tmo_clr_i) tmo_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tmo_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tmo_q <= tmo_d;
    end
  end

  assign count_o    = cnt_q;
  assign tmo_o      = tmo_q;
  assign win_open_o = en_i && (cnt_q >= win_i);
endmodule

// File: rtl/dmt_keys.sv
module dmt_keys
  import dmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              pre_we_i,
  input  logic [7:0]        pre_key_i,
  input  logic              clr_we_i,
  input  logic [DATA_W-1:0] clr_val_i,
  input  logic              win_open_i,
  input  logic              bad1_clr_i,
  input  logic              bad2_clr_i,
  output logic              bad1_o,
  output logic              bad2_o,
  output logic              svc_o
);
  logic armed_q, armed_d, bad1_q, bad1_d, bad2_q, bad2_d;
  logic pre_act, clr_act, pre_ok;

  assign pre_act = pre_we_i && en_i;
  assign clr_act = clr_we_i && en_i;
  assign pre_ok  = (pre_key_i == ARM_KEY);
  assign svc_o   = clr_act && armed_q && win_open_i && (clr_val_i == SVC_KEY);

  always_comb begin
    armed_d = armed_q;
    if (!en_i)        armed_d = 1'b0;
    else if (pre_act) armed_d = pre_ok;
    else if (clr_act) armed_d = 1'b0;

    bad1_d = bad1_q;
    if (pre_act && !pre_ok) bad1_d = 1'b1;
    else if (bad1_clr_i)    bad1_d = 1'b0;

    bad2_d = bad2_q;
    if (clr_act && !svc_o) bad2_d = 1'b1;
    else if (bad2_clr_i)   bad2_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      bad1_q  <= 1'b0;
      bad2_q  <= 1'b0;
    end else begin
      armed_q <= armed_d;
      bad1_q  <= bad1_d;
      bad2_q  <= bad2_d;
    end
  end

  assign bad1_o = bad1_q;
  assign bad2_o = bad2_q;
endmodule

// File: rtl/fetch_deadman.sv
module fetch_deadman
  import dmt_pkg::*;
#(
  parameter int          CNT_W      = 32,
  parameter int unsigned LIMIT_INIT = 1000,
  parameter int unsigned WIN_INIT   = 500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_i,
  input  logic              reg_wr_i,
  input  logic [7:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              event_o,
  output logic              cause_o
);
  logic [NSLOT-1:0]  we;
  alias_e            al;
  logic              en_q, en_d, blk_q, blk_d, cause_q, cause_d;
  logic [CNT_W-1:0]  lim_q, lim_d, win_q, win_d, wd_c, count_q;
  logic              win_open, tmo_q, expire, svc_ok, bad1, bad2;
  logic [DATA_W-1:0] key_val;
  logic [2:0]        sta_clr;

  dmt_regdec #(.NREG(NSLOT)) u_dec (
    .wr_i(reg_wr_i), .addr_i(reg_addr_i), .blk_i(blk_q), .we_o(we), .al_o(al)
  );

  // a key written through the clear alias is taken as zero
  assign key_val = (al == AL_CLR) ? '0 : reg_wdata_i;
  assign sta_clr = (we[RG_STA] && al == AL_CLR) ? reg_wdata_i[7:5] : 3'b000;
  assign wd_c    = reg_wdata_i[CNT_W-1:0];

  dmt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en_i(en_q), .fetch_i(fetch_i), .svc_i(svc_ok),
    .limit_i(lim_q), .win_i(win_q), .tmo_clr_i(sta_clr[0]),
    .count_o(count_q), .win_open_o(win_open), .tmo_o(tmo_q), .expire_o(expire)
  );

  dmt_keys u_keys (
    .clk(clk), .rst_n(rst_n), .en_i(en_q),
    .pre_we_i(we[RG_PRE]), .pre_key_i(key_val[15:8]),
    .clr_we_i(we[RG_CLR]), .clr_val_i(key_val),
    .win_open_i(win_open), .bad1_clr_i(sta_clr[2]), .bad2_clr_i(sta_clr[1]),
    .bad1_o(bad1), .bad2_o(bad2), .svc_o(svc_ok)
  );

  // next state of the writable registers
  always_comb begin
    en_d = en_q;
    if (we[RG_CTL]) en_d = apply_bit(al, en_q, reg_wdata_i[EN_BIT]);
    blk_d = en_q && !en_d;

    lim_d = lim_q;
    if (we[RG_LIM]) begin
      case (al)
        AL_CLR:  lim_d = lim_q & ~wd_c;
        AL_SET:  lim_d = lim_q | wd_c;
        default: lim_d = wd_c;
      endcase
    end

    win_d = win_q;
    if (we[RG_WIN]) begin
      case (al)
        AL_CLR:  win_d = win_q & ~wd_c;
        AL_SET:  win_d = win_q | wd_c;
        default: win_d = wd_c;
      endcase
    end

    cause_d = cause_q;
    if (expire)          cause_d = 1'b1;
    else if (we[RG_CAU]) cause_d = apply_bit(al, cause_q, reg_wdata_i[CAUSE_BIT]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      blk_q   <= 1'b0;
      lim_q   <= CNT_W'(LIMIT_INIT);
      win_q   <= CNT_W'(WIN_INIT);
      cause_q <= 1'b0;
    end else begin
      en_q    <= en_d;
      blk_q   <= blk_d;
      lim_q   <= lim_d;
      win_q   <= win_d;
      cause_q <= cause_d;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i[7:4])
      4'h0: reg_rdata_o[EN_BIT] = en_q;
      4'h3: reg_rdata_o[7:0] = {bad1, bad2, tmo_q, 4'b0000, win_open};
      4'h4: reg_rdata_o[CNT_W-1:0] = count_q;
      4'h6: reg_rdata_o[CNT_W-1:0] = lim_q;
      4'h7: reg_rdata_o[CNT_W-1:0] = win_q;
      4'h8: reg_rdata_o[CAUSE_BIT] = cause_q;
      default: reg_rdata_o = '0;
    endcase
  end

  assign event_o = tmo_q | bad1 | bad2;
  assign cause_o = cause_q;
endmodule

// File: rtl/dmt_checker.sv
module dmt_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr,
  input logic [7:0]       addr,
  input logic [31:0]      wdata,
  input logic             en,
  input logic             blk,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] limit,
  input logic             tmo,
  input logic             cause,
  input logic             bad1
);
  // R2: disabled timer holds a zero count
  a_r2_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (count == '0));

  // R3: count moves by at most one per cycle, or returns to zero
  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (count == '0) || (count == $past(count)) || (count == $past(count) + 1'b1));

  // R4: the timeout flag and the cause bit rise together
  a_r4_cause_with_tmo: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo) |-> cause);

  // R6: a wrong arming key on an enabled timer flags bit 7
  a_r6_bad_first: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !blk && wr && addr[7:4] == 4'h1 && addr[3:2] != 2'b01 &&
     addr[1:0] == 2'b00 && wdata[15:8] != 8'h40) |=> bad1);

  // R11: writes in the blackout cycle leave limit and enable unchanged
  a_r11_blackout: assert property (@(posedge clk) disable iff (!rst_n)
    (blk && wr) |=> ($stable(limit) && !en));
endmodule

bind fetch_deadman dmt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr(reg_wr_i), .addr(reg_addr_i), .wdata(reg_wdata_i),
  .en(en_q), .blk(blk_q), .count(count_q), .limit(lim_q), .tmo(tmo_q),
  .cause(cause_q), .bad1(bad1)
);

// File: tb/fetch_deadman_bench.sv
`timescale 1ns/1ps
module fetch_deadman_bench;
  logic        clk = 1'b0;
  logic        rst_n, fetch, wr;
  logic [7:0]  addr;
  logic [31:0] wdata, rdv;
  logic        event_o, cause_o;
  int          n_tests = 0, n_fail = 0;
  logic        done = 1'b0;

  always #4 clk = ~clk;

  fetch_deadman #(.CNT_W(16), .LIMIT_INIT(40), .WIN_INIT(20)) u_fetch_deadman (
    .clk(clk), .rst_n(rst_n), .fetch_i(fetch), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdv), .event_o(event_o), .cause_o(cause_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr1(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic wr_pair(input logic [7:0] a1, input logic [31:0] d1,
                         input logic [7:0] a2, input logic [31:0] d2);
    @(negedge clk); wr = 1'b1; addr = a1; wdata = d1;
    @(negedge clk); addr = a2; wdata = d2;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; #1; v = rdv;
  endtask

  task automatic do_fetch(input int n);
    if (n > 0) begin
      @(negedge clk); fetch = 1'b1;
      repeat (n) @(negedge clk);
      fetch = 1'b0;
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; fetch = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    rd(8'h00, v); chk("R1 ctl reset", v, 32'h0);
    rd(8'h30, v); chk("R1 status reset", v, 32'h0);
    rd(8'h40, v); chk("R1 count reset", v, 32'h0);
    rd(8'h60, v); chk("R1 limit reset", v, 32'd40);
    rd(8'h70, v); chk("R1 interval reset", v, 32'd20);
    rd(8'h80, v); chk("R1 cause reset", v, 32'h0);
    chk("R8 event reset", {31'b0, event_o}, 32'h0);

    // R1 aliases and alignment
    wr1(8'h60, 32'h0F); wr1(8'h68, 32'h30); rd(8'h60, v); chk("R1 set alias", v, 32'h3F);
    wr1(8'h64, 32'h0C); rd(8'h64, v); chk("R1 clear alias", v, 32'h33);
    wr1(8'h61, 32'h01); rd(8'h60, v); chk("R1 unaligned ignored", v, 32'h33);

    // R2 disabled: no counting, keys ignored
    do_fetch(5); rd(8'h40, v); chk("R2 no count when off", v, 32'h0);
    wr1(8'h10, 32'h1); wr1(8'h20, 32'h3); rd(8'h30, v); chk("R2 keys ignored when off", v, 32'h0);

    // R3 R5 R7 R8 sweep of service point against window threshold
    foreach (int_lims[i]) ;
    for (int li = 0; li < 2; li++) begin
      int lim;
      lim = (li == 0) ? 6 : 9;
      for (int w = 0; w < lim; w++) begin
        for (int k = 0; k < lim; k++) begin
          int cnt_after;
          logic [31:0] st;
          wr1(8'h60, lim); wr1(8'h70, w); wr1(8'h08, 32'h8000);
          do_fetch(k);
          rd(8'h40, v); chk("R3 count", v, k);
          rd(8'h30, v); chk("R5 window flag", v, (k >= w) ? 32'h1 : 32'h0);
          wr1(8'h10, 32'h4000); wr1(8'h20, 32'h8);
          cnt_after = (k >= w) ? 0 : k;
          st = ((cnt_after >= w) ? 32'h1 : 32'h0) | ((k < w) ? 32'h40 : 32'h0);
          rd(8'h40, v); chk("R7 count after service", v, cnt_after);
          rd(8'h30, v); chk("R7 status after service", v, st);
          chk("R8 event after service", {31'b0, event_o}, (k < w) ? 32'h1 : 32'h0);
          wr1(8'h34, 32'hE0); wr1(8'h04, 32'h8000);
        end
      end
    end

    // R4 expiry, R9 status clearing, R10 cause
    wr1(8'h60, 32'd5); wr1(8'h70, 32'd2); wr1(8'h08, 32'h8000);
    rd(8'h00, v); chk("R2 enable bit reads back", v, 32'h8000);
    do_fetch(7);
    rd(8'h40, v); chk("R3 count stops at limit", v, 32'd5);
    rd(8'h30, v); chk("R4 timeout flag", v, 32'h21);
    rd(8'h80, v); chk("R4 cause set", v, 32'h20);
    chk("R8 event on timeout", {31'b0, event_o}, 32'h1);
    wr1(8'h30, 32'hE0); rd(8'h30, v); chk("R9 plain write ignored", v, 32'h21);
    wr1(8'h38, 32'hE0); rd(8'h30, v); chk("R9 set write ignored", v, 32'h21);
    wr1(8'h34, 32'h20); rd(8'h30, v); chk("R9 clear alias", v, 32'h01);
    chk("R10 cause kept", {31'b0, cause_o}, 32'h1);
    wr1(8'h84, 32'h20); rd(8'h80, v); chk("R10 cause cleared", v, 32'h0);
    wr1(8'h10, 32'h4000); wr1(8'h20, 32'h8);
    rd(8'h40, v); chk("R7 service after expiry", v, 32'h0);
    do_fetch(3);

    // R6 first key checks
    wr1(8'h10, 32'h4100); rd(8'h30, v); chk("R6 bad first key", v, 32'h81);
    chk("R8 event on bad key", {31'b0, event_o}, 32'h1);
    wr1(8'h34, 32'h80);
    wr1(8'h14, 32'h4000); rd(8'h30, v); chk("R6 clear alias key is zero", v, 32'h81);
    wr1(8'h34, 32'h80);
    // R7 second key checks
    wr1(8'h10, 32'h4000); wr1(8'h20, 32'h9);
    rd(8'h30, v); chk("R7 wrong clear value", v, 32'h41);
    rd(8'h40, v); chk("R7 count kept", v, 32'd3);
    wr1(8'h34, 32'h40);
    wr1(8'h20, 32'h8); rd(8'h30, v); chk("R7 clear without arm", v, 32'h41);
    wr1(8'h34, 32'h40);
    wr1(8'h10, 32'hFFFF40FF); wr1(8'h20, 32'h8);
    rd(8'h40, v); chk("R6 key field only", v, 32'h0);
    rd(8'h30, v); chk("R6 no flag on good key", v, 32'h0);

    // R11 blackout
    wr_pair(8'h04, 32'h8000, 8'h60, 32'd7);
    rd(8'h60, v); chk("R11 limit write dropped", v, 32'd5);
    wr1(8'h08, 32'h8000);
    wr_pair(8'h04, 32'h8000, 8'h08, 32'h8000);
    rd(8'h00, v); chk("R11 enable write dropped", v, 32'h0);
    wr1(8'h60, 32'd7); rd(8'h60, v); chk("R11 write after blackout", v, 32'd7);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  int int_lims[2] = '{6, 9};
endmodule